// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Sequencer

This block sits beside an 8-bit processor core and decides when an interrupt is entered. It watches an active-low maskable request line, an active-low non-maskable line, and a software-interrupt request from the core. At each instruction boundary strobe, and only while it is idle, it picks at most one source. The non-maskable source ranks first, the maskable line second and the software request third. The maskable line only counts when the core's mask flag is clear.

Once a source is accepted, the block takes a snapshot of the core's registers. It pushes seven bytes downward through the stack pointer and reports that the mask flag must now be set. It then reads the two-byte handler address from the vector pair of the chosen source. To finish, it gives the core a one-cycle strobe that loads the new program counter and the final stack pointer.

The memory side is a valid/ready port. The block asserts a write request or a read request. The transfer completes only in a cycle where `mem_ready` is high. Until then the address and write data are held steady. Read data is taken in the cycle in which the read completes.

Top module: `intr_vector_seq`

## Requirements
- R1: A high-to-low transition on `nmi_n` marks a non-maskable request pending. It stays pending until accepted. A new transition seen in the very cycle an earlier one is accepted stays pending, so the core is entered a second time.
- R2: A low level on `irq_n` is accepted only when `i_flag` is 0 at the boundary. With `i_flag` at 1 it has no effect: `busy` stays 0.
- R3: When several sources qualify at the same boundary, the pending non-maskable request wins over `irq_n`, and `irq_n` wins over `swi_req`. A source that loses and is still asserted is taken at a later boundary.
- R4: A source is accepted only on a clock edge where `insn_boundary` is 1 and the block is idle (`busy`=0). Boundaries seen while `busy`=1 are ignored. `busy` is 1 from the cycle after acceptance until the load cycle ends.
- R5: The stack frame is written as seven byte writes, in this order: PC[7:0], PC[15:8], X[7:0], X[15:8], A, B, CCR. The first byte goes to address SP, and each later byte goes one address lower. Write and read are never requested together.
- R6: A memory transfer completes only on an edge with `mem_ready`=1. While a request waits, `mem_addr` and `mem_wdata` hold their values.
- R7: Two vector bytes are read, the high byte first at the base and then the low byte at base+1. The base is 0xFFF8 for `irq_n`, 0xFFFA for `swi_req` and 0xFFFC for `nmi_n`.
- R8: After the second vector read, `pc_load` and `sp_load` are high together for exactly one cycle. In that cycle `pc_out` = {high byte, low byte} and `sp_out` = the sampled SP minus 7.
- R9: `i_load` pulses high for one cycle, in the first cycle after the last stack write completes, and `i_out` is 1.
- R10: After reset the block is idle, requests nothing from memory, raises no load strobe, and holds no pending non-maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, edge |
| swi_req | input | 1 | Software interrupt request from the core |
| i_flag | input | 1 | Current interrupt mask flag |
| insn_boundary | input | 1 | Instruction boundary strobe |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 16 | Index register to save |
| a_in | input | 8 | Accumulator A to save |
| b_in | input | 8 | Accumulator B to save |
| ccr_in | input | 8 | Condition codes to save |
| sp_in | input | 16 | Stack pointer at acceptance |
| mem_ready | input | 1 | Memory accepts the current transfer |
| mem_rdata | input | 8 | Read data, valid with a completing read |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| busy | output | 1 | Entry sequence in progress |
| sp_load | output | 1 | Stack pointer load strobe |
| sp_out | output | 16 | New stack pointer |
| pc_load | output | 1 | Program counter load strobe |
| pc_out | output | 16 | Handler address |
| i_load | output | 1 | Mask flag load strobe |
| i_out | output | 1 | New mask flag value |

## Verification
Two events can fall in the same edge. The first is a fresh falling edge on `nmi_n` arriving on the very edge that accepts an earlier non-maskable request. The bench provokes it by making `insn_boundary` and the second low-going step of `nmi_n` appear together. Its reference model must then show a second complete entry at the next boundary. The second is several sources asserted together at one boundary, with the maskable line held low afterwards. The model judges both the winner and the later entry of the loser, and it runs cycle by cycle under random stalls on `mem_ready`.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_SWI  = 2'd2,
    SRC_NMI  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2,
    ST_DONE = 2'd3
  } st_e;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic nmi_n,
  input  logic swi_req,
  input  logic i_mask,
  input  logic boundary,
  input  logic idle,
  output src_e pick,
  output logic take
);
  logic nmi_prev;
  logic nmi_pend;
  logic nmi_fall;

  assign nmi_fall = nmi_prev & ~nmi_n;

  // Fixed ranking: edge-held non-maskable, then unmasked level request, then software.
  always_comb begin
    if (nmi_pend)                pick = SRC_NMI;
    else if (!irq_n && !i_mask)  pick = SRC_IRQ;
    else if (swi_req)            pick = SRC_SWI;
    else                         pick = SRC_NONE;
  end

  assign take = boundary && idle && (pick != SRC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      nmi_pend <= (nmi_pend & ~(take && pick == SRC_NMI)) | nmi_fall;
    end
  end
endmodule

// File: rtl/intr_vec_sel.sv
module intr_vec_sel
  import intr_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [15:0] VEC_IRQ = 16'hFFF8,
  parameter logic [15:0] VEC_SWI = 16'hFFFA,
  parameter logic [15:0] VEC_NMI = 16'hFFFC
) (
  input  src_e          src,
  output logic [AW-1:0] base
);
  always_comb begin
    unique case (src)
      SRC_NMI: base = AW'(VEC_NMI);
      SRC_SWI: base = AW'(VEC_SWI);
      default: base = AW'(VEC_IRQ);
    endcase
  end
endmodule

// File: rtl/intr_push_seq.sv
module intr_push_seq
  import intr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] vec_base,
  input  logic [2*DW-1:0] pc_in,
  input  logic [2*DW-1:0] x_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          idle,
  output logic          done,
  output logic [AW-1:0] sp_cur,
  output logic [2*DW-1:0] pc_new,
  output logic          i_load
);
  localparam int NBYTES = 7;
  localparam int SW     = $clog2(NBYTES);
  localparam logic [SW-1:0] LAST = SW'(NBYTES - 1);

  st_e            st;
  logic [SW-1:0]  step;
  logic [AW-1:0]  base_q;
  logic [DW-1:0]  frame [NBYTES];
  logic [DW-1:0]  vhi, vlo;

  assign idle    = (st == ST_IDLE);
  assign done    = (st == ST_DONE);
  assign mem_we  = (st == ST_PUSH);
  assign mem_re  = (st == ST_VEC);
  assign mem_addr  = mem_re ? base_q + AW'(step[0]) : sp_cur;
  assign mem_wdata = frame[step];
  assign pc_new    = {vhi, vlo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      step   <= '0;
      sp_cur <= '0;
      base_q <= '0;
      vhi    <= '0;
      vlo    <= '0;
      i_load <= 1'b0;
      for (int k = 0; k < NBYTES; k++) frame[k] <= '0;
    end else begin
      i_load <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          frame[0] <= pc_in[DW-1:0];
          frame[1] <= pc_in[2*DW-1:DW];
          frame[2] <= x_in[DW-1:0];
          frame[3] <= x_in[2*DW-1:DW];
          frame[4] <= a_in;
          frame[5] <= b_in;
          frame[6] <= ccr_in;
          sp_cur   <= sp_in;
          base_q   <= vec_base;
          step     <= '0;
          st       <= ST_PUSH;
        end
        ST_PUSH: if (mem_ready) begin
          sp_cur <= sp_cur - AW'(1);
          if (step == LAST) begin
            step   <= '0;
            i_load <= 1'b1;
            st     <= ST_VEC;
          end else begin
            step <= step + SW'(1);
          end
        end
        ST_VEC: if (mem_ready) begin
          if (step[0] == 1'b0) begin
            vhi  <= mem_rdata;
            step <= SW'(1);
          end else begin
            vlo  <= mem_rdata;
            step <= '0;
            st   <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intr_vector_seq.sv
module intr_vector_seq
  import intr_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter logic [15:0] VEC_IRQ = 16'hFFF8,
  parameter logic [15:0] VEC_SWI = 16'hFFFA,
  parameter logic [15:0] VEC_NMI = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_n,
  input  logic            nmi_n,
  input  logic            swi_req,
  input  logic            i_flag,
  input  logic            insn_boundary,
  input  logic [2*DW-1:0] pc_in,
  input  logic [2*DW-1:0] x_in,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   b_in,
  input  logic [DW-1:0]   ccr_in,
  input  logic [AW-1:0]   sp_in,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            busy,
  output logic            sp_load,
  output logic [AW-1:0]   sp_out,
  output logic            pc_load,
  output logic [2*DW-1:0] pc_out,
  output logic            i_load,
  output logic            i_out
);
  src_e          pick;
  logic          take;
  logic          idle;
  logic          done;
  logic [AW-1:0] vec_base;

  intr_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .nmi_n    (nmi_n),
    .swi_req  (swi_req),
    .i_mask   (i_flag),
    .boundary (insn_boundary),
    .idle     (idle),
    .pick     (pick),
    .take     (take)
  );

  intr_vec_sel #(
    .AW(AW), .VEC_IRQ(VEC_IRQ), .VEC_SWI(VEC_SWI), .VEC_NMI(VEC_NMI)
  ) u_vsel (
    .src  (pick),
    .base (vec_base)
  );

  intr_push_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take),
    .vec_base  (vec_base),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .a_in      (a_in),
    .b_in      (b_in),
    .ccr_in    (ccr_in),
    .sp_in     (sp_in),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .idle      (idle),
    .done      (done),
    .sp_cur    (sp_out),
    .pc_new    (pc_out),
    .i_load    (i_load)
  );

  assign busy    = ~idle;
  assign pc_load = done;
  assign sp_load = done;
  assign i_out   = 1'b1;
endmodule

// File: rtl/intr_vector_seq_chk.sv
module intr_vector_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_we,
  input logic          mem_re,
  input logic          busy,
  input logic          pc_load,
  input logic          sp_load,
  input logic          i_load
);
  // R5: never a write and a read at once
  p_rw_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R5: consecutive frame bytes go one address lower
  p_stack_descend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ready) |=> (!mem_we || mem_addr == $past(mem_addr) - AW'(1)));

  // R6: a waiting write keeps address and data
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

  // R6: a waiting read keeps its address
  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !mem_ready) |=> (mem_re && $stable(mem_addr)));

  // R7: vector reads stay in the top vector region
  p_vec_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr >= AW'(16'hFFF8)));

  // R8: load strobes come together and last one cycle
  p_load_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load == sp_load);
  p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  // R9: mask load is a single pulse right after stacking
  p_mask_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    i_load |=> !i_load);
  p_mask_then_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    i_load |-> mem_re);

  // R4: idle block issues no memory traffic
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
endmodule

bind intr_vector_seq intr_vector_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .busy      (busy),
  .pc_load   (pc_load),
  .sp_load   (sp_load),
  .i_load    (i_load)
);

// File: tb/intr_vector_seq_bench.sv
module intr_vector_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_n = 1'b1, nmi_n = 1'b1, swi_req = 1'b0, i_flag = 1'b0;
  logic        insn_boundary = 1'b0;
  logic [15:0] pc_in = 16'h5000, x_in = 16'h2608, sp_in = 16'h01FF;
  logic [7:0]  a_in = 8'h26, b_in = 8'h56, ccr_in = 8'hC0;
  logic        mem_ready = 1'b1;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, sp_out, pc_out;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re, busy, sp_load, pc_load, i_load, i_out;

  always #5 clk = ~clk;

  function automatic logic [7:0] vec_mem(input logic [15:0] a);
    return {a[3:0], ~a[3:0]};
  endfunction
  assign mem_rdata = vec_mem(mem_addr);

  intr_vector_seq u_intr_vector_seq (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .swi_req(swi_req),
    .i_flag(i_flag), .insn_boundary(insn_boundary), .pc_in(pc_in), .x_in(x_in),
    .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .busy(busy),
    .sp_load(sp_load), .sp_out(sp_out), .pc_load(pc_load), .pc_out(pc_out),
    .i_load(i_load), .i_out(i_out)
  );

  int checks = 0, fails = 0, cycles = 0, entries = 0;

  // behavioural reference: phase 0 idle, 1 stacking, 2 vector read, 3 load
  int          m_phase = 0, m_k = 0;
  logic [15:0] m_sp = 0, m_vec = 0;
  logic [7:0]  m_hi = 0, m_lo = 0, m_frame [7];
  logic        m_pend = 0, m_prev = 1, m_iload = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_k = 0; m_sp = 0; m_vec = 0; m_hi = 0; m_lo = 0;
      m_pend = 0; m_prev = 1; m_iload = 0;
    end else begin
      bit fall, clr, nl;
      fall = m_prev && !nmi_n;
      m_prev = nmi_n;
      clr = 0; nl = 0;
      case (m_phase)
        0: if (insn_boundary) begin
          int src; src = 0;
          if (m_pend) begin src = 3; clr = 1; end           // R1, R3
          else if (!irq_n && !i_flag) src = 1;              // R2
          else if (swi_req) src = 2;
          if (src != 0) begin
            m_vec = (src == 3) ? 16'hFFFC : (src == 2) ? 16'hFFFA : 16'hFFF8;
            m_frame[0] = pc_in[7:0]; m_frame[1] = pc_in[15:8];
            m_frame[2] = x_in[7:0];  m_frame[3] = x_in[15:8];
            m_frame[4] = a_in; m_frame[5] = b_in; m_frame[6] = ccr_in;
            m_sp = sp_in; m_k = 0; m_phase = 1; entries++;
          end
        end
        1: if (mem_ready) begin
          m_sp = m_sp - 16'd1;
          if (m_k == 6) begin m_k = 0; m_phase = 2; nl = 1; end
          else m_k++;
        end
        2: if (mem_ready) begin
          if (m_k == 0) begin m_hi = vec_mem(m_vec); m_k = 1; end
          else begin m_lo = vec_mem(m_vec + 16'd1); m_k = 0; m_phase = 3; end
        end
        default: m_phase = 0;
      endcase
      m_pend = (m_pend && !clr) || fall;
      m_iload = nl;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string bt;
    bt = rst_n ? "R4 busy" : "R10 busy after reset";
    chk(bt, {15'd0, busy}, {15'd0, m_phase != 0});
    chk(rst_n ? "R5 mem_we" : "R10 mem_we", {15'd0, mem_we}, {15'd0, m_phase == 1});
    chk(rst_n ? "R7 mem_re" : "R10 mem_re", {15'd0, mem_re}, {15'd0, m_phase == 2});
    chk(rst_n ? "R8 pc_load" : "R10 pc_load", {15'd0, pc_load}, {15'd0, m_phase == 3});
    chk("R8 sp_load", {15'd0, sp_load}, {15'd0, m_phase == 3});
    chk("R9 i_load", {15'd0, i_load}, {15'd0, m_iload});
    if (m_iload) chk("R9 i_out", {15'd0, i_out}, 16'd1);
    if (m_phase == 1) begin
      chk("R5 R6 stack address", mem_addr, m_sp);
      chk("R5 R6 stack byte", {8'd0, mem_wdata}, {8'd0, m_frame[m_k]});
    end
    if (m_phase == 2) chk("R7 vector address", mem_addr, m_vec + 16'(m_k));
    if (m_phase == 3) begin
      chk("R8 pc_out", pc_out, {m_hi, m_lo});
      chk("R8 sp_out", sp_out, m_sp);
    end
  end

  // R6: stall pattern on memory ready
  bit          stall_on = 0;
  logic [7:0]  lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_on ? lfsr[0] : 1'b1;
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic bnd;
    @(negedge clk) insn_boundary = 1'b1;
    @(negedge clk) insn_boundary = 1'b0;
  endtask
  task automatic wait_idle;
    for (int i = 0; i < 200 && (busy || m_phase != 0); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    wait_cyc(20000);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    // R2: masked level request has no effect
    i_flag = 1'b1; irq_n = 1'b0;
    bnd(); wait_cyc(4);
    chk("R2 masked request stays idle", {15'd0, busy}, 16'd0);
    // R2, R5, R7, R8: unmasked request
    i_flag = 1'b0;
    bnd(); irq_n = 1'b1; wait_idle();
    // R7: software request with stalls, R6
    stall_on = 1; pc_in = 16'hA9F0; x_in = 16'h9000; sp_in = 16'h0100;
    swi_req = 1'b1; bnd(); swi_req = 1'b0; wait_idle();
    // R3: all three at one boundary; loser irq then taken later
    nmi_n = 1'b0; irq_n = 1'b0; swi_req = 1'b1; wait_cyc(1);
    bnd(); wait_idle();
    pc_in = 16'h1234; bnd(); wait_idle();
    irq_n = 1'b1; swi_req = 1'b0; nmi_n = 1'b1;
    // R4: boundaries during a sequence are ignored; edge held pending (R1)
    swi_req = 1'b1; bnd(); swi_req = 1'b0;
    nmi_n = 1'b0; wait_cyc(1); nmi_n = 1'b1;
    bnd(); wait_cyc(1); bnd(); wait_idle();
    chk("R1 R4 idle after ignored boundaries", {15'd0, busy}, 16'd0);
    bnd(); wait_idle();
    // R1: fresh edge in the accepting cycle stays pending
    stall_on = 0;
    nmi_n = 1'b0; wait_cyc(1); nmi_n = 1'b1; wait_cyc(1);
    @(negedge clk) begin insn_boundary = 1'b1; nmi_n = 1'b0; end
    @(negedge clk) insn_boundary = 1'b0;
    wait_idle(); nmi_n = 1'b1;
    sp_in = 16'h0007; bnd(); wait_idle();
    chk("R1 second entry count", 16'(entries), 16'd8);
    wait_cyc(3);
    finish_run();
  end
endmodule